// File: doc/BRIEF.md
# Two-Channel DC-Removal High-Pass Filter with Offset Freeze

This block sits after a decimator and removes the DC level from a stream of signed audio samples that alternate between a left channel and a right channel. Each sample carries a channel tag. The block keeps one running DC estimate per channel, held as a fixed-point accumulator, and nudges it toward each new sample by a fraction of the difference. It subtracts the integer part of that estimate from the sample and saturates the result to the input width. Each output appears one clock after its input.

A freeze control stops the estimates from moving while the subtraction goes on. This supports system offset calibration. First run the filter with tracking on until the estimates settle. Then set freeze, and from that point the learned offsets are removed from every later sample. When the filter is turned off and not frozen, samples pass through unchanged and the estimates stay as they are.

Top module: `dc_offset_hpf`

## Requirements
- R1: Synchronous reset clears both channel estimates to zero and drives out_valid low. The first sample after reset therefore comes out equal to its input.
- R2: out_valid is in_valid delayed by exactly one clock, and out_ch on a valid output equals the in_ch of the sample that produced it.
- R3: In tracking mode (hpf_enable=1, hpf_freeze=0), out_data equals in_data minus floor(E/2^K). E is the channel's estimate before this sample updates it, and K is SHIFT_K (default 10).
- R4: In tracking mode each valid sample x updates its channel's estimate as E := E + floor((x*2^K - E)/2^K). E is a signed value with K fraction bits.
- R5: in_ch=0 selects the left estimate and in_ch=1 selects the right estimate. A sample never changes the other channel's estimate.
- R6: While hpf_freeze=1, whatever the value of hpf_enable, neither estimate changes, and each output is still in_data minus floor(E/2^K) of its channel.
- R7: With hpf_enable=0 and hpf_freeze=0, out_data equals in_data and neither estimate changes.
- R8: When the difference does not fit, out_data clamps to the signed DATA_W range: the most negative code is -2^(DATA_W-1) and the most positive is 2^(DATA_W-1)-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hpf_enable | input | 1 | Estimate tracking on |
| hpf_freeze | input | 1 | Hold estimates, keep subtracting |
| in_valid | input | 1 | Input sample strobe |
| in_ch | input | 1 | Channel tag, 0 left, 1 right |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_ch | output | 1 | Channel tag of output |
| out_data | output | DATA_W | Signed filtered sample |

## Verification
The assertions check on every cycle:
- the one-clock valid and channel timing;
- that out_valid is low after reset;
- that the estimates do not move while frozen;
- that a sample leaves the other channel's estimate alone;
- exact pass-through, with the estimates held, when the filter is off.

The arithmetic of the estimate update, its settling toward a constant input, the frozen subtraction of a learned offset, and saturation at both ends can only be shown by the bench. It runs long trained sequences against its behavioural model and checks them.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_TRACK = 2'd1,
    MODE_HOLD  = 2'd2
  } dcr_mode_e;

  function automatic dcr_mode_e decode_mode(input logic enable, input logic freeze);
    if (freeze)      return MODE_HOLD;
    else if (enable) return MODE_TRACK;
    else             return MODE_PASS;
  endfunction
endpackage

// File: rtl/dcr_est_bank.sv
module dcr_est_bank #(
  parameter int NUM_CH = 2,
  parameter int ACC_W  = 34,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [CH_W-1:0]         wr_ch,
  input  logic [ACC_W-1:0]        wr_data,
  output logic [NUM_CH*ACC_W-1:0] est_all
);
  logic [ACC_W-1:0] mem [NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_ch] <= wr_data;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
    assign est_all[g*ACC_W +: ACC_W] = mem[g];
  end
endmodule

// File: rtl/dcr_est_update.sv
module dcr_est_update #(
  parameter int DATA_W  = 24,
  parameter int SHIFT_K = 10,
  localparam int ACC_W  = DATA_W + SHIFT_K,
  localparam int DIFF_W = ACC_W + 1
) (
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [ACC_W-1:0]  est_q,
  output logic signed [ACC_W-1:0]  est_d
);
  logic signed [DIFF_W-1:0] x_scaled;
  logic signed [DIFF_W-1:0] e_ext;
  logic signed [DIFF_W-1:0] diff;
  logic signed [DIFF_W-1:0] step;
  logic signed [DIFF_W-1:0] sum;

  always_comb begin
    x_scaled = {sample[DATA_W-1], sample, {SHIFT_K{1'b0}}};
    e_ext    = {est_q[ACC_W-1], est_q};
    diff     = x_scaled - e_ext;
    step     = diff >>> SHIFT_K;
    sum      = e_ext + step;
    est_d    = sum[ACC_W-1:0];
  end
endmodule

// File: rtl/dcr_out_stage.sv
module dcr_out_stage #(
  parameter int DATA_W = 24,
  localparam int SUB_W = DATA_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     in_ch,
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [DATA_W-1:0] offset,
  output logic                     out_valid,
  output logic                     out_ch,
  output logic signed [DATA_W-1:0] out_data
);
  localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [SUB_W-1:0]  sub;
  logic signed [DATA_W-1:0] clamped;

  always_comb begin
    sub = {sample[DATA_W-1], sample} - {offset[DATA_W-1], offset};
    if (sub[SUB_W-1] != sub[SUB_W-2])
      clamped = sub[SUB_W-1] ? MIN_V : MAX_V;
    else
      clamped = sub[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ch    <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_ch   <= in_ch;
        out_data <= clamped;
      end
    end
  end
endmodule

// File: rtl/dc_offset_hpf.sv
module dc_offset_hpf
  import dcr_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int SHIFT_K = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     hpf_enable,
  input  logic                     hpf_freeze,
  input  logic                     in_valid,
  input  logic                     in_ch,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic                     out_ch,
  output logic signed [DATA_W-1:0] out_data
);
  localparam int NUM_CH = 2;
  localparam int ACC_W  = DATA_W + SHIFT_K;

  dcr_mode_e                  mode;
  logic [NUM_CH*ACC_W-1:0]    est_all;
  logic signed [ACC_W-1:0]    est_sel;
  logic signed [ACC_W-1:0]    est_next;
  logic signed [DATA_W-1:0]   est_int;
  logic signed [DATA_W-1:0]   offset;
  logic                       wr_en;

  always_comb begin
    mode    = decode_mode(hpf_enable, hpf_freeze);
    est_sel = est_all[in_ch*ACC_W +: ACC_W];
    est_int = est_sel[ACC_W-1:SHIFT_K];
    offset  = (mode == MODE_PASS) ? '0 : est_int;
    wr_en   = in_valid && (mode == MODE_TRACK);
  end

  dcr_est_bank #(.NUM_CH(NUM_CH), .ACC_W(ACC_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_ch   (in_ch),
    .wr_data (est_next),
    .est_all (est_all)
  );

  dcr_est_update #(.DATA_W(DATA_W), .SHIFT_K(SHIFT_K)) u_update (
    .sample (in_data),
    .est_q  (est_sel),
    .est_d  (est_next)
  );

  dcr_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ch     (in_ch),
    .sample    (in_data),
    .offset    (offset),
    .out_valid (out_valid),
    .out_ch    (out_ch),
    .out_data  (out_data)
  );
endmodule

// File: rtl/dcr_checker.sv
module dcr_checker #(
  parameter int DATA_W = 24,
  parameter int ACC_W  = 34
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     hpf_enable,
  input logic                     hpf_freeze,
  input logic                     in_valid,
  input logic                     in_ch,
  input logic signed [DATA_W-1:0] in_data,
  input logic                     out_valid,
  input logic                     out_ch,
  input logic signed [DATA_W-1:0] out_data,
  input logic [2*ACC_W-1:0]       est_all
);
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !out_valid);

  a_r2_valid_rise: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_valid) |=> out_valid);

  a_r2_valid_drop: assert property (@(posedge clk) disable iff (rst)
    (!rst && !in_valid) |=> !out_valid);

  a_r2_ch_follow: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_valid) |=> (out_ch == $past(in_ch)));

  a_r6_freeze_hold: assert property (@(posedge clk) disable iff (rst)
    (!rst && hpf_freeze) |=> $stable(est_all));

  a_r7_pass_through: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_valid && !hpf_enable && !hpf_freeze)
      |=> (out_data == $past(in_data)) && $stable(est_all));

  a_r5_left_isolated: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_ch) |=> $stable(est_all[ACC_W-1:0]));

  a_r5_right_isolated: assert property (@(posedge clk) disable iff (rst)
    (!rst && !in_ch) |=> $stable(est_all[2*ACC_W-1:ACC_W]));
endmodule

bind dc_offset_hpf dcr_checker #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hpf_enable (hpf_enable),
  .hpf_freeze (hpf_freeze),
  .in_valid   (in_valid),
  .in_ch      (in_ch),
  .in_data    (in_data),
  .out_valid  (out_valid),
  .out_ch     (out_ch),
  .out_data   (out_data),
  .est_all    (est_all)
);

// File: tb/test_dc_offset_hpf.sv
module test_dc_offset_hpf;
  localparam int DATA_W  = 24;
  localparam int SHIFT_K = 10;
  localparam longint MAXV = (64'sd1 <<< (DATA_W-1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (DATA_W-1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hpf_enable = 1'b0;
  logic hpf_freeze = 1'b0;
  logic in_valid = 1'b0;
  logic in_ch = 1'b0;
  logic signed [DATA_W-1:0] in_data = '0;
  logic out_valid;
  logic out_ch;
  logic signed [DATA_W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  longint acc [2];

  always #2 clk = ~clk;

  dc_offset_hpf #(.DATA_W(DATA_W), .SHIFT_K(SHIFT_K)) i_dc_offset_hpf (
    .clk(clk), .rst(rst), .hpf_enable(hpf_enable), .hpf_freeze(hpf_freeze),
    .in_valid(in_valid), .in_ch(in_ch), .in_data(in_data),
    .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One input cycle: drive at negedge, model at posedge, compare at next negedge.
  task automatic step(input string tag, input bit v, input bit ch,
                      input longint x, input bit en, input bit fz);
    longint est_int, y;
    bit exp_valid;
    in_valid = v; in_ch = ch; in_data = DATA_W'(x);
    hpf_enable = en; hpf_freeze = fz;
    @(posedge clk);
    exp_valid = v;
    y = 0;
    if (v) begin
      est_int = acc[ch] >>> SHIFT_K;
      if (!en && !fz) y = x;
      else y = x - est_int;
      if (y > MAXV) y = MAXV;
      if (y < MINV) y = MINV;
      if (en && !fz) acc[ch] = acc[ch] + (((x <<< SHIFT_K) - acc[ch]) >>> SHIFT_K);
    end
    @(negedge clk);
    if (out_valid !== exp_valid) check({tag, " valid"}, longint'(out_valid), longint'(exp_valid));
    else if (v) begin
      if (out_ch !== ch) check({tag, " ch"}, longint'(out_ch), longint'(ch));
      else check(tag, longint'(out_data), y);
    end else checks++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    acc[0] = 0; acc[1] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset out_valid", longint'(out_valid), 0);
    rst = 1'b0;
    // R1: first samples after reset see zero estimates (frozen, so no update)
    step("R1 first left", 1, 0, 12345, 1, 1);
    step("R1 first right", 1, 1, -777, 0, 1);
    // R7: pass-through when off
    step("R7 pass left", 1, 0, 4000, 0, 0);
    step("R7 pass right", 1, 1, MINV, 0, 0);
    // R2: gap produces no output
    step("R2 idle", 0, 0, 0, 1, 0);
    // R3/R4/R5: tracking distinct DC per channel
    for (int i = 0; i < 6000; i++) begin
      step("R3 R4 R5 track left", 1, 0, 1000 + (i % 7) * 50, 1, 0);
      step("R3 R4 R5 track right", 1, 1, -30000 + (i % 5) * 100, 1, 0);
      if (i % 500 == 0) step("R2 gap", 0, 1, 0, 1, 0);
    end
    // R5: long run on one channel only, then the other must still show its offset
    for (int i = 0; i < 300; i++) step("R5 left only", 1, 0, -5000, 1, 0);
    step("R5 right kept", 1, 1, -30000, 0, 1);
    // R6: freeze keeps subtracting held offsets, with enable on and off
    for (int i = 0; i < 200; i++) begin
      step("R6 freeze left", 1, 0, (i % 2) ? 9000 : -9000, i[0], 1);
      step("R6 freeze right", 1, 1, i * 37, 1, 1);
    end
    // R7: pass with held estimates, then tracking resumes from them
    for (int i = 0; i < 20; i++) step("R7 pass held", 1, i[0], i * 1000 - 7000, 0, 0);
    for (int i = 0; i < 20; i++) step("R4 resume", 1, i[0], 2500, 1, 0);
    // R8: saturation in both directions
    for (int i = 0; i < 16000; i++) begin
      step("R8 train left", 1, 0, MAXV, 1, 0);
      step("R8 train right", 1, 1, MINV, 1, 0);
    end
    step("R8 clamp low", 1, 0, MINV, 1, 1);
    step("R8 clamp high", 1, 1, MAXV, 1, 1);
    // R1: reset again clears estimates
    rst = 1'b1;
    step("R1 during reset", 0, 0, 0, 0, 0);
    rst = 1'b0;
    acc[0] = 0; acc[1] = 0;
    step("R1 cleared left", 1, 0, 55, 1, 1);
    step("R1 cleared right", 1, 1, -55, 1, 1);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule